// File: doc/BRIEF.md
# Ping-pong OUT endpoint buffer

This block holds received data for one bulk or interrupt OUT endpoint of a USB device. It owns two equal storage banks and fills them in turn: the first valid packet after enabling goes to bank 0, the next to bank 1, then back to bank 0. Each bank has a full flag. The receive path sets the flag when a packet completes with a good CRC. Firmware clears the flag once it has drained that bank. While a flag is set, that bank is protected. An OUT is refused with NAK only when both banks are held.

On the bus side the block sees a start strobe, a byte strobe with data, and an end strobe that carries the CRC verdict. It answers with a one-cycle ACK or NAK pulse. Packets that are too long are cut to the bank size and still accepted. Packets with a bad CRC leave no trace.

On the firmware side the block shows the flag of each bank and which bank is current. It also gives the byte count of the current bank as a low and a high byte, a read port that steps forward through the bank, one clear strobe per bank, and a level interrupt gated by an enable.

Top module: `pp_out_ep`

## Requirements
- R1: While either `ep_enable` or `ep_config` is low, no handshake is produced and no flag is set. Both flags, the write bank and the firmware bank return to 0 on the next clock.
- R2: A packet that starts while at least one flag is clear, and ends with `rx_crc_ok` high, gives a one-cycle `hs_ack`. The pulse appears in the cycle after the end strobe, and in that same cycle the write bank's flag is visible as set.
- R3: Accepted packets go alternately to bank 0 and bank 1, starting with bank 0 after reset or enable, so the flags are set alternately.
- R4: A packet that starts while both flags are set is answered with a one-cycle `hs_nak` when its CRC is good. It stores nothing, sets no flag and does not move the write bank.
- R5: A packet that ends with `rx_crc_ok` low gives no handshake, sets no flag and does not move the write bank.
- R6: `{fw_count_hi, fw_count_lo}` is the byte count stored for the current firmware bank while that bank's flag is set, and 0 otherwise. A zero-length packet sets its flag with a count of 0.
- R7: A packet longer than DEPTH bytes keeps only its first DEPTH bytes, reports a count of DEPTH, and is still acknowledged when its CRC is good.
- R8: `fw_data` shows the byte of the current bank at the read index. The index starts at 0, and each `fw_rd` pulse moves it up by one while the bank's flag is set and the index is below the count. Otherwise `fw_rd` does nothing.
- R9: A clear strobe for the current firmware bank whose flag is set clears that flag on the next clock, toggles `fw_bank` and resets the read index to 0.
- R10: A clear strobe for a bank whose flag is clear, or for the bank that is not current, has no effect.
- R11: `irq` is high exactly when `irq_en` is high and at least one flag is set.
- R12: `hs_ack` and `hs_nak` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_enable | input | 1 | Endpoint enabled |
| ep_config | input | 1 | Endpoint configured |
| irq_en | input | 1 | Interrupt enable |
| rx_start | input | 1 | Start of an OUT data packet |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | End of packet strobe |
| rx_crc_ok | input | 1 | CRC verdict, valid with `rx_end` |
| hs_ack | output | 1 | ACK handshake pulse |
| hs_nak | output | 1 | NAK handshake pulse |
| fw_rd | input | 1 | Firmware byte read strobe |
| fw_clr0 | input | 1 | Release strobe for bank 0 |
| fw_clr1 | input | 1 | Release strobe for bank 1 |
| fw_bank | output | 1 | Bank currently presented to firmware |
| flag_b0 | output | 1 | Bank 0 holds a packet |
| flag_b1 | output | 1 | Bank 1 holds a packet |
| fw_count_lo | output | 8 | Byte count of current bank, low byte |
| fw_count_hi | output | 8 | Byte count of current bank, high byte |
| fw_data | output | 8 | Byte at the read index of the current bank |
| irq | output | 1 | Interrupt request |

## Verification
The bench first runs directed sequences, each aimed at one behaviour. One packet at a time shows ACK timing and bank order. Two back-to-back packets followed by a third expose the NAK condition. A bad-CRC packet placed between good ones shows that the write bank does not advance. A zero-length packet and an oversized packet probe the two ends of the byte count. Clear strobes aimed at the wrong bank or at an empty bank show that nothing moves. A long pseudo-random mix of packet lengths, CRC results, reads, clears and interrupt-enable changes then drives both banks through every fill and release order. A behavioural model compares every output on every cycle, which separates a wrong bank choice from a wrong count or from stale data.

// File: rtl/pp_out_pkg.sv
package pp_out_pkg;

    localparam int BYTE_W     = 8;
    localparam int CNT_PORT_W = 16;

    typedef enum logic [1:0] {
        HS_NONE = 2'd0,
        HS_ACK  = 2'd1,
        HS_NAK  = 2'd2
    } hs_e;

    typedef struct packed {
        logic open;
        logic blocked;
    } rx_state_t;

    function automatic logic both_held(input logic [1:0] f);
        return f[0] & f[1];
    endfunction

endpackage

// File: rtl/pp_bank_mem.sv
module pp_bank_mem
    import pp_out_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cnt_load,
    input  logic [CW-1:0]     cnt_in,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CW-1:0]     cnt_q
);

    logic [BYTE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_load) begin
            cnt_q <= cnt_in;
        end
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/pp_ep_ctrl.sv
module pp_ep_ctrl
    import pp_out_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          rx_start,
    input  logic          rx_valid,
    input  logic          rx_end,
    input  logic          rx_crc_ok,
    input  logic          fw_rd,
    input  logic [1:0]    fw_clr,
    input  logic [CW-1:0] cnt_b0,
    input  logic [CW-1:0] cnt_b1,
    output logic [1:0]    flags,
    output logic          wr_bank,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [1:0]    cnt_load,
    output logic [CW-1:0] cnt_val,
    output logic          rd_bank,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] fw_cnt,
    output hs_e           hs
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    rx_state_t     rx_q;
    logic [CW-1:0] rx_cnt;
    logic [1:0]    flags_q;
    logic          wr_q;
    logic          rd_q;
    logic [CW-1:0] idx_q;
    hs_e           hs_q;

    logic [CW-1:0] rd_cnt;
    logic          byte_ok;
    logic          pkt_done;
    logic          pkt_good;
    logic          pkt_refuse;
    logic          clr_hit;
    logic          rd_step;
    logic [1:0]    flags_d;

    always_comb begin
        rd_cnt     = rd_q ? cnt_b1 : cnt_b0;
        byte_ok    = active && rx_q.open && !rx_q.blocked && rx_valid && !rx_start && !rx_end;
        wr_en      = byte_ok && (rx_cnt < DEPTH_C);
        pkt_done   = active && rx_q.open && rx_end && !rx_start;
        pkt_good   = pkt_done && rx_crc_ok && !rx_q.blocked;
        pkt_refuse = pkt_done && rx_crc_ok && rx_q.blocked;
        clr_hit    = active && fw_clr[rd_q] && flags_q[rd_q];
        rd_step    = active && fw_rd && flags_q[rd_q] && (idx_q < rd_cnt) && !clr_hit;
        cnt_load   = 2'b00;
        if (pkt_good) begin
            cnt_load[wr_q] = 1'b1;
        end
        flags_d = flags_q;
        if (pkt_good) begin
            flags_d[wr_q] = 1'b1;
        end
        if (clr_hit) begin
            flags_d[rd_q] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            rx_q    <= '0;
            rx_cnt  <= '0;
            flags_q <= 2'b00;
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            idx_q   <= '0;
            hs_q    <= HS_NONE;
        end else begin
            hs_q <= pkt_good ? HS_ACK : (pkt_refuse ? HS_NAK : HS_NONE);
            if (rx_start) begin
                rx_q   <= '{open: 1'b1, blocked: both_held(flags_q)};
                rx_cnt <= '0;
            end else if (pkt_done) begin
                rx_q.open <= 1'b0;
            end else if (wr_en) begin
                rx_cnt <= rx_cnt + 1'b1;
            end
            flags_q <= flags_d;
            if (pkt_good) begin
                wr_q <= ~wr_q;
            end
            if (clr_hit) begin
                rd_q  <= ~rd_q;
                idx_q <= '0;
            end else if (rd_step) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign flags   = flags_q;
    assign wr_bank = wr_q;
    assign wr_addr = rx_cnt[AW-1:0];
    assign cnt_val = rx_cnt;
    assign rd_bank = rd_q;
    assign rd_addr = idx_q[AW-1:0];
    assign fw_cnt  = flags_q[rd_q] ? rd_cnt : '0;
    assign hs      = hs_q;

    AST_OFF_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !active |=> (flags_q == 2'b00 && hs_q == HS_NONE)); // R1
    AST_ACK_FLIPS_BANK: assert property (@(posedge clk) disable iff (rst)
        (hs_q == HS_ACK) |-> (flags_q[$past(wr_q)] && wr_q != $past(wr_q))); // R3
    AST_NAK_HOLDS_BANK: assert property (@(posedge clk) disable iff (rst)
        (hs_q == HS_NAK) |-> $stable(wr_q)); // R4
    AST_BAD_CRC_SILENT: assert property (@(posedge clk) disable iff (rst)
        (active && rx_q.open && rx_end && !rx_start && !rx_crc_ok)
        |=> (hs_q == HS_NONE && $stable(wr_q))); // R5
    AST_COUNT_CAPPED: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= DEPTH_C); // R7
    AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        flags_q[rd_q] |-> (idx_q <= rd_cnt)); // R8
    AST_WRONG_CLEAR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (active && fw_clr[~rd_q] && !fw_clr[rd_q]) |=> $stable(rd_q)); // R10

endmodule

// File: rtl/pp_out_ep.sv
module pp_out_ep
    import pp_out_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ep_enable,
    input  logic       ep_config,
    input  logic       irq_en,
    input  logic       rx_start,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_end,
    input  logic       rx_crc_ok,
    output logic       hs_ack,
    output logic       hs_nak,
    input  logic       fw_rd,
    input  logic       fw_clr0,
    input  logic       fw_clr1,
    output logic       fw_bank,
    output logic       flag_b0,
    output logic       flag_b1,
    output logic [7:0] fw_count_lo,
    output logic [7:0] fw_count_hi,
    output logic [7:0] fw_data,
    output logic       irq
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic              active;
    logic [1:0]        flags;
    logic              wr_bank;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [1:0]        cnt_load;
    logic [CW-1:0]     cnt_val;
    logic              rd_bank;
    logic [AW-1:0]     rd_addr;
    logic [CW-1:0]     fw_cnt;
    hs_e               hs;
    logic [BYTE_W-1:0] bank_rd  [2];
    logic [CW-1:0]     bank_cnt [2];
    logic [CNT_PORT_W-1:0] cnt_wide;

    assign active = ep_enable && ep_config;

    pp_ep_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .rx_start  (rx_start),
        .rx_valid  (rx_valid),
        .rx_end    (rx_end),
        .rx_crc_ok (rx_crc_ok),
        .fw_rd     (fw_rd),
        .fw_clr    ({fw_clr1, fw_clr0}),
        .cnt_b0    (bank_cnt[0]),
        .cnt_b1    (bank_cnt[1]),
        .flags     (flags),
        .wr_bank   (wr_bank),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .rd_bank   (rd_bank),
        .rd_addr   (rd_addr),
        .fw_cnt    (fw_cnt),
        .hs        (hs)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        pp_bank_mem #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_mem (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (wr_bank == 1'(b))),
            .wr_addr  (wr_addr),
            .wr_data  (rx_data),
            .cnt_load (cnt_load[b]),
            .cnt_in   (cnt_val),
            .rd_addr  (rd_addr),
            .rd_data  (bank_rd[b]),
            .cnt_q    (bank_cnt[b])
        );
    end

    always_comb begin
        cnt_wide = '0;
        cnt_wide[CW-1:0] = fw_cnt;
    end

    assign hs_ack      = (hs == HS_ACK);
    assign hs_nak      = (hs == HS_NAK);
    assign fw_bank     = rd_bank;
    assign flag_b0     = flags[0];
    assign flag_b1     = flags[1];
    assign fw_count_lo = cnt_wide[7:0];
    assign fw_count_hi = cnt_wide[15:8];
    assign fw_data     = bank_rd[rd_bank];
    assign irq         = irq_en && (flags != 2'b00);

    AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        !(hs_ack && hs_nak)); // R12
    AST_ACK_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        hs_ack |-> (flag_b0 || flag_b1)); // R2

endmodule

// File: tb/pp_out_ep_tb_top.sv
`timescale 1ns/100ps
module pp_out_ep_tb_top;

    localparam int TB_DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ep_enable = 1'b0, ep_config = 1'b0, irq_en = 1'b0;
    logic       rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0, rx_crc_ok = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       fw_rd = 1'b0, fw_clr0 = 1'b0, fw_clr1 = 1'b0;
    logic       hs_ack, hs_nak, fw_bank, flag_b0, flag_b1, irq;
    logic [7:0] fw_count_lo, fw_count_hi, fw_data;

    always #2 clk = ~clk;

    pp_out_ep #(.DEPTH(TB_DEPTH)) dut_i (
        .clk(clk), .rst(rst), .ep_enable(ep_enable), .ep_config(ep_config),
        .irq_en(irq_en), .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .hs_ack(hs_ack), .hs_nak(hs_nak),
        .fw_rd(fw_rd), .fw_clr0(fw_clr0), .fw_clr1(fw_clr1), .fw_bank(fw_bank),
        .flag_b0(flag_b0), .flag_b1(flag_b1), .fw_count_lo(fw_count_lo),
        .fw_count_hi(fw_count_hi), .fw_data(fw_data), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    int ack_seen = 0;
    int nak_seen = 0;

    // behavioural reference state
    bit [1:0]  m_flags = 0;
    bit        m_wr = 0, m_rd = 0, m_open = 0, m_blk = 0, m_ack = 0, m_nak = 0;
    int        m_idx = 0;
    int        m_cnt [2] = '{0, 0};
    bit [7:0]  m_mem [2][TB_DEPTH];
    bit [7:0]  tq [$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit [1:0] o_flags;
        bit o_wr, o_rd, clr;
        if (rst || !(ep_enable && ep_config)) begin
            m_flags = 0; m_wr = 0; m_rd = 0; m_open = 0; m_blk = 0;
            m_ack = 0; m_nak = 0; m_idx = 0;
            if (rst) begin m_cnt[0] = 0; m_cnt[1] = 0; end
        end else begin
            o_flags = m_flags; o_wr = m_wr; o_rd = m_rd;
            m_ack = 0; m_nak = 0;
            clr = (o_rd ? fw_clr1 : fw_clr0) && o_flags[o_rd];
            if (rx_start) begin
                m_open = 1; m_blk = o_flags[0] && o_flags[1]; tq.delete();
            end else if (rx_end && m_open) begin
                if (rx_crc_ok) begin
                    if (m_blk) m_nak = 1;
                    else begin
                        m_ack = 1;
                        for (int i = 0; i < tq.size(); i++) m_mem[o_wr][i] = tq[i];
                        m_cnt[o_wr] = tq.size();
                        m_flags[o_wr] = 1;
                        m_wr = !o_wr;
                    end
                end
                m_open = 0;
            end else if (rx_valid && m_open && !m_blk && tq.size() < TB_DEPTH) begin
                tq.push_back(rx_data);
            end
            if (clr) begin
                m_flags[o_rd] = 0; m_rd = !o_rd; m_idx = 0;
            end else if (fw_rd && o_flags[o_rd] && m_idx < m_cnt[o_rd]) begin
                m_idx++;
            end
        end
    end

    always @(negedge clk) begin
        int exp_cnt;
        if (!rst) begin
            if (hs_ack) ack_seen++;
            if (hs_nak) nak_seen++;
            chk("R3 flags", int'({flag_b1, flag_b0}), int'(m_flags));
            chk("R2 ack", int'(hs_ack), int'(m_ack));
            chk("R4 nak", int'(hs_nak), int'(m_nak));
            chk("R12 exclusive", int'(hs_ack && hs_nak), 0);
            chk("R9 bank", int'(fw_bank), int'(m_rd));
            exp_cnt = m_flags[m_rd] ? m_cnt[m_rd] : 0;
            chk("R6 count", int'({fw_count_hi, fw_count_lo}), exp_cnt);
            if (m_flags[m_rd] && m_idx < m_cnt[m_rd])
                chk("R8 data", int'(fw_data), int'(m_mem[m_rd][m_idx]));
            chk("R11 irq", int'(irq), int'(irq_en && (m_flags != 0)));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic send(input int n, input bit crc, input int seed);
        rx_start = 1; step(); rx_start = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_data = 8'(seed + i * 7); step();
        end
        rx_valid = 0; rx_end = 1; rx_crc_ok = crc; step();
        rx_end = 0; rx_crc_ok = 0; step();
    endtask

    task automatic rd_n(input int n);
        for (int i = 0; i < n; i++) begin fw_rd = 1; step(); end
        fw_rd = 0; step();
    endtask

    task automatic clr(input int b);
        if (b == 0) fw_clr0 = 1; else fw_clr1 = 1;
        step(); fw_clr0 = 0; fw_clr1 = 0; step();
    endtask

    initial begin
        int a0, n0;
        repeat (3) step();
        rst = 0; step();
        chk("R1 reset flags", int'({flag_b1, flag_b0}), 0);
        chk("R11 reset irq", int'(irq), 0);
        chk("R9 reset bank", int'(fw_bank), 0);

        ep_enable = 1;
        send(4, 1, 3);
        chk("R1 unconfigured no flag", int'({flag_b1, flag_b0}), 0);
        chk("R1 unconfigured no ack", ack_seen, 0);
        ep_config = 1; irq_en = 1; step();

        send(5, 1, 10);
        chk("R2 first ack", ack_seen, 1);
        chk("R3 bank0 first", int'({flag_b1, flag_b0}), 1);
        chk("R6 count five", int'(fw_count_lo), 5);
        chk("R11 irq on", int'(irq), 1);
        send(3, 1, 40);
        chk("R3 bank1 second", int'({flag_b1, flag_b0}), 3);
        n0 = nak_seen;
        send(2, 1, 70);
        chk("R4 nak when both held", nak_seen, n0 + 1);
        clr(1);
        chk("R10 wrong bank clear", int'({flag_b1, flag_b0}), 3);
        chk("R10 bank unchanged", int'(fw_bank), 0);
        rd_n(5);
        rd_n(2);
        clr(0);
        chk("R9 clear moves bank", int'(fw_bank), 1);
        chk("R9 flag0 cleared", int'(flag_b0), 0);
        a0 = ack_seen;
        send(4, 0, 90);
        chk("R5 bad crc no ack", ack_seen, a0);
        chk("R5 bad crc no flag", int'(flag_b0), 0);
        rd_n(3); clr(1);
        send(0, 1, 0);
        chk("R6 zlp flag", int'(flag_b0), 1);
        chk("R6 zlp count", int'({fw_count_hi, fw_count_lo}), 0);
        clr(0);
        a0 = ack_seen;
        send(TB_DEPTH + 5, 1, 5);
        chk("R7 oversize ack", ack_seen, a0 + 1);
        chk("R7 oversize count", int'(fw_count_lo), TB_DEPTH);
        rd_n(TB_DEPTH + 3);
        clr(1);
        clr(1);
        chk("R10 clear of empty bank", int'(fw_bank), 0);
        irq_en = 0; step();
        send(2, 1, 1); send(2, 1, 2);
        chk("R11 irq masked", int'(irq), 0);
        ep_enable = 0; step(); step();
        chk("R1 disable clears flags", int'({flag_b1, flag_b0}), 0);
        chk("R1 disable clears bank", int'(fw_bank), 0);
        ep_enable = 1; step();

        for (int it = 0; it < 600; it++) begin
            case ($urandom_range(0, 5))
                0, 1: send($urandom_range(0, TB_DEPTH + 3), ($urandom_range(0, 9) != 0), $urandom_range(0, 255));
                2: rd_n($urandom_range(0, TB_DEPTH + 1));
                3: clr($urandom_range(0, 1));
                4: begin irq_en = $urandom_range(0, 1); step(); end
                default: begin
                    if ($urandom_range(0, 19) == 0) begin ep_config = 0; step(); ep_config = 1; end
                    step();
                end
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule